// File: doc/BRIEF.md
# Word-serial variable-precision significand adder

This block adds or subtracts two floating-point operands whose significands are 1 to 32 words of 64 bits each. Each operand also has a 16-bit exponent biased by 32768 and a sign bit. Both operands use the same word count, and the result has that count too. The operand words enter least significant word first over a streaming read port, both operands side by side, one word pair per cycle. The block then does the following in order. It picks the larger magnitude and computes the exponent distance. It derives two guard bits and a sticky bit from the bits that alignment pushes out. It runs a 64-bit carry chain word by word. It normalizes and rounds the result in one of four modes. Finally it streams the result significand out, least significant word first, while it holds the result exponent, sign and flags steady.

The significand has no hidden bit. A normalized operand has the top bit of its top word set, so its value lies in [1, 2). The operands given to the block are normalized and nonzero. The result is normalized unless it is an exact zero.

Top module: `vp_sig_adder`

## Requirements
- R1: After reset, busy, in_ready and out_valid are low.
- R2: A start pulse seen while busy is low captures the header. The block then takes exactly len_m1+1 word pairs on cycles where in_valid and in_ready are both high. The result significand is the exact sum of the operands after rounding, taking b as negated when op_sub is 1. Its exponent is the exponent of the larger-magnitude operand, corrected only by the normalization of R4, R5 or R7.
- R3: The operation is an effective subtraction when sign_a differs from sign_b XOR op_sub. In that case the smaller magnitude is subtracted from the larger one. The result sign is the sign of the larger operand (for operand b, that is sign_b XOR op_sub). Magnitude is compared first by exponent and then by significand.
- R4: When an addition carries out of the top bit, the result is shifted right by one bit and its exponent is raised by one.
- R5: When leading zeros appear after a subtraction, the result is shifted left until its top bit is set. Its exponent is lowered by the same count.
- R6: rmode selects the rounding: 0 is nearest with ties to even, 1 is toward zero, 2 is toward plus infinity, and 3 is toward minus infinity. Each result is correctly rounded to len_m1+1 words.
- R7: When rounding up carries past the top bit, the significand becomes 1 followed by zeros and the exponent rises by one.
- R8: An exact cancellation raises out_zero. All result words and the exponent field are then zero and out_range is low. The sign is 1 only under mode 3.
- R9: The result leaves as len_m1+1 consecutive out_valid words, least significant first. out_last is high on the final word only. out_exp, out_sign, out_zero and out_range hold steady across the stream. The top bit of the final word is set unless out_zero is high.
- R10: out_range goes high when the true result exponent exceeds 65535 or falls below 0. out_exp then carries that exponent's low 16 bits.
- R11: A start pulse seen while busy is high has no effect on the result in progress. in_ready is high only while operand words are being taken.
- R12: An alignment distance larger than the significand length leaves the smaller operand acting only through the guard and sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation and captures the header |
| op_sub | input | 1 | 1 subtracts b from a, 0 adds |
| rmode | input | 2 | Rounding mode, encoded as in R6 |
| len_m1 | input | 5 | Significand word count minus one |
| exp_a | input | 16 | Biased exponent of a |
| sign_a | input | 1 | Sign of a |
| exp_b | input | 16 | Biased exponent of b |
| sign_b | input | 1 | Sign of b |
| in_valid | input | 1 | Operand word pair present |
| in_ready | output | 1 | Block takes a word pair this cycle |
| in_word_a | input | 64 | Word of a, least significant first |
| in_word_b | input | 64 | Word of b, least significant first |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | Result word present |
| out_last | output | 1 | Final result word |
| out_word | output | 64 | Result significand word |
| out_exp | output | 16 | Result biased exponent |
| out_sign | output | 1 | Result sign |
| out_zero | output | 1 | Result is exactly zero |
| out_range | output | 1 | Result exponent is outside the 16-bit field |

## Verification
The assertions check the framing of the result stream on every cycle: the last-word flag, back-to-back words with a steady header, a set top bit on normalized results, clean zero results, and ready only while busy. The numerical behaviour can only be shown by the bench scenarios. That covers alignment at bit and word distances, carry-out and cancellation normalization, every rounding mode with both signs, round-up overflow, far-away operands, exponent range faults and a start pulse sent during a load. In each scenario the bench compares the design against an exact wide-integer rounding model.

// File: rtl/vp_sig_adder.sv
module vp_sig_adder #(
  parameter int MAXW = 32,
  parameter int WB   = 64,
  parameter int EW   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      op_sub,
  input  logic [1:0]                rmode,
  input  logic [$clog2(MAXW)-1:0]   len_m1,
  input  logic [EW-1:0]             exp_a,
  input  logic                      sign_a,
  input  logic [EW-1:0]             exp_b,
  input  logic                      sign_b,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WB-1:0]             in_word_a,
  input  logic [WB-1:0]             in_word_b,
  output logic                      busy,
  output logic                      out_valid,
  output logic                      out_last,
  output logic [WB-1:0]             out_word,
  output logic [EW-1:0]             out_exp,
  output logic                      out_sign,
  output logic                      out_zero,
  output logic                      out_range
);
  localparam int SW  = MAXW * WB;
  localparam int LW  = $clog2(MAXW);
  localparam int XW  = EW + 2;
  localparam int DW  = $clog2(SW + 4) + 1;
  localparam int FPW = 2 * SW + WB;
  localparam int PW  = $clog2(FPW) + 1;
  localparam int EMAX = (1 << EW) - 1;

  typedef enum logic [2:0] {IDLE, LOAD, PREP, ALGN, ADDW, NORM, RND, OUTW} st_t;
  st_t st;

  logic [LW-1:0] lm, cnt;
  logic [1:0] md;
  logic sa, sb, esub, co, zr, rng;
  logic signed [XW-1:0] ea, eb, dif, en;
  logic [SW-1:0] fa, fb;
  logic [2:0] lo;
  logic [DW-1:0] dd;

  logic [PW-1:0] nbits, wbase, base;
  logic [FPW-1:0] fbp;
  logic [WB-1:0] swd, bwd, addend;
  logic [WB:0] sum;
  logic bbig, g, r, stk, inc, ovf;
  logic [SW:0] rsum;
  int dm2;

  assign nbits  = PW'((32'(lm) + 1) * WB);
  assign wbase  = PW'(32'(cnt) * WB);
  assign base   = wbase + PW'(dd);
  assign fbp    = {{(FPW-SW){1'b0}}, fb};
  assign swd    = fbp[base +: WB];
  assign bwd    = fa[wbase +: WB];
  assign addend = esub ? ~swd : swd;
  assign sum    = {1'b0, bwd} + {1'b0, addend} + {{WB{1'b0}}, co};

  assign bbig = (eb > ea) || ((eb == ea) && (fb > fa));
  assign dif  = bbig ? eb - ea : ea - eb;

  assign g = (dd >= DW'(1)) ? fbp[dd - DW'(1)] : 1'b0;
  assign r = (dd >= DW'(2)) ? fbp[dd - DW'(2)] : 1'b0;
  always_comb begin
    dm2 = int'(dd) - 2;
    if (dm2 <= 0)       stk = 1'b0;
    else if (dm2 >= SW) stk = |fb;
    else                stk = |(fb << (SW - dm2));
  end

  always_comb begin
    case (md)
      2'd0:    inc = lo[2] & (lo[1] | lo[0] | fa[0]);
      2'd1:    inc = 1'b0;
      2'd2:    inc = (|lo) & ~sa;
      default: inc = (|lo) & sa;
    endcase
  end
  assign rsum = {1'b0, fa} + {{SW{1'b0}}, inc};
  assign ovf  = rsum[nbits];
  assign en   = ea + $signed({{(XW-1){1'b0}}, ovf});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; lm <= '0; md <= '0;
      sa <= 1'b0; sb <= 1'b0; esub <= 1'b0; co <= 1'b0; zr <= 1'b0; rng <= 1'b0;
      ea <= '0; eb <= '0; fa <= '0; fb <= '0; lo <= '0; dd <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          lm <= len_m1; md <= rmode;
          ea <= $signed({2'b00, exp_a}); eb <= $signed({2'b00, exp_b});
          sa <= sign_a; sb <= sign_b ^ op_sub;
          fa <= '0; fb <= '0; cnt <= '0; zr <= 1'b0; rng <= 1'b0;
          st <= LOAD;
        end
        LOAD: if (in_valid) begin
          fa[wbase +: WB] <= in_word_a;
          fb[wbase +: WB] <= in_word_b;
          if (cnt == lm) begin cnt <= '0; st <= PREP; end
          else cnt <= cnt + 1'b1;
        end
        PREP: begin
          esub <= sa ^ sb;
          if (bbig) begin fa <= fb; fb <= fa; ea <= eb; sa <= sb; end
          dd <= (dif > $signed(XW'(SW + 3))) ? DW'(SW + 3) : dif[DW-1:0];
          st <= ALGN;
        end
        ALGN: begin
          lo  <= esub ? 3'd0 - {g, r, stk} : {g, r, stk};
          co  <= esub ? ({g, r, stk} == 3'd0) : 1'b0;
          cnt <= '0;
          st  <= ADDW;
        end
        ADDW: begin
          fa[wbase +: WB] <= sum[WB-1:0];
          if (cnt == lm) begin
            co <= esub ? 1'b0 : sum[WB];
            cnt <= '0; st <= NORM;
          end else begin
            co <= sum[WB]; cnt <= cnt + 1'b1;
          end
        end
        NORM: begin
          if (co) begin
            fa <= (fa >> 1) | (SW'(1) << (nbits - PW'(1)));
            lo <= {fa[0], lo[2], lo[1] | lo[0]};
            ea <= ea + 1'b1; co <= 1'b0; st <= RND;
          end else if (fa == '0 && lo == 3'd0) begin
            zr <= 1'b1; st <= RND;
          end else if (!fa[nbits - PW'(1)]) begin
            fa <= {fa[SW-2:0], lo[2]};
            lo <= {lo[1:0], 1'b0};
            ea <= ea - 1'b1;
          end else st <= RND;
        end
        RND: begin
          if (zr) begin
            sa <= (md == 2'd3); fa <= '0; ea <= '0; rng <= 1'b0;
          end else begin
            fa  <= ovf ? (SW'(1) << (nbits - PW'(1))) : rsum[SW-1:0];
            ea  <= en;
            rng <= (en < 0) || (en > $signed(XW'(EMAX)));
          end
          cnt <= '0; st <= OUTW;
        end
        OUTW: begin
          if (cnt == lm) begin cnt <= '0; st <= IDLE; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy      = (st != IDLE);
  assign in_ready  = (st == LOAD);
  assign out_valid = (st == OUTW);
  assign out_last  = out_valid && (cnt == lm);
  assign out_word  = bwd;
  assign out_exp   = ea[EW-1:0];
  assign out_sign  = sa;
  assign out_zero  = zr;
  assign out_range = rng;
endmodule

module vp_sig_adder_chk #(
  parameter int WB = 64,
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          busy,
  input logic          out_valid,
  input logic          out_last,
  input logic [WB-1:0] out_word,
  input logic [EW-1:0] out_exp,
  input logic          out_sign,
  input logic          out_zero,
  input logic          out_range
);
  a_r11_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  a_r11_no_ready_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r9_last_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r9_stream_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && $stable(out_exp) && $stable(out_sign)
                                  && $stable(out_zero) && $stable(out_range)));
  a_r9_top_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !out_zero) |-> out_word[WB-1]);
  a_r8_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_word == '0 && out_exp == '0 && !out_range));
endmodule

bind vp_sig_adder vp_sig_adder_chk #(.WB(WB), .EW(EW)) u_vp_sig_adder_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy),
  .out_valid(out_valid), .out_last(out_last), .out_word(out_word),
  .out_exp(out_exp), .out_sign(out_sign), .out_zero(out_zero), .out_range(out_range)
);

// File: tb/test_vp_sig_adder.sv
module test_vp_sig_adder;
  localparam int MW = 4;
  localparam int WB = 64;
  localparam int SW = MW * WB;
  localparam int MX = 2 * SW + 8;
  localparam logic [63:0] H = 64'h8000_0000_0000_0000;
  localparam int B = 32768;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, op_sub, sign_a, sign_b, in_valid;
  logic [1:0] rmode;
  logic [1:0] len_m1;
  logic [15:0] exp_a, exp_b;
  logic [63:0] in_word_a, in_word_b;
  logic in_ready, busy, out_valid, out_last, out_sign, out_zero, out_range;
  logic [63:0] out_word;
  logic [15:0] out_exp;

  vp_sig_adder #(.MAXW(MW)) i_vp_sig_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .rmode(rmode),
    .len_m1(len_m1), .exp_a(exp_a), .sign_a(sign_a), .exp_b(exp_b), .sign_b(sign_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_word_a(in_word_a), .in_word_b(in_word_b),
    .busy(busy), .out_valid(out_valid), .out_last(out_last), .out_word(out_word),
    .out_exp(out_exp), .out_sign(out_sign), .out_zero(out_zero), .out_range(out_range));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [63:0] la [4];
  logic [63:0] lb [4];
  logic [63:0] qw [$];
  bit ql [$];
  logic [15:0] x_exp;
  bit x_sign, x_zero, x_range;
  logic [63:0] w_e;
  bit l_e;
  logic [63:0] seed = 64'h2545_F491_4F6C_DD1D;

  function automatic logic [63:0] nxt();
    seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
    return seed;
  endfunction

  // Exact model: form the true sum or difference as a wide integer, then round it to n bits.
  task automatic model(input int len, input int ea_i, input int eb_i, input bit sa_i,
                       input bit sb_i, input bit sub_i, input int md_i);
    logic [SW-1:0] fa_v, fb_v, big, sml;
    logic [MX-1:0] V, S, keep, rem, half, one;
    int n, d, p, e, sh, ebig;
    bit sbe, bb, es, sgn, inc;
    n = len * 64; fa_v = '0; fb_v = '0; one = 1;
    for (int k = 0; k < len; k++) begin fa_v[k*64 +: 64] = la[k]; fb_v[k*64 +: 64] = lb[k]; end
    sbe = sb_i ^ sub_i;
    bb = (eb_i > ea_i) || (eb_i == ea_i && fb_v > fa_v);
    ebig = bb ? eb_i : ea_i;
    d = bb ? eb_i - ea_i : ea_i - eb_i;
    sgn = bb ? sbe : sa_i;
    big = bb ? fb_v : fa_v;
    sml = bb ? fa_v : fb_v;
    es = sa_i ^ sbe;
    if (d > n + 3) d = n + 3;
    V = MX'(big) << (n + 3);
    S = MX'(sml) << (n + 3 - d);
    V = es ? V - S : V + S;
    if (V == '0) begin
      x_zero = 1; x_sign = (md_i == 3); x_exp = 16'h0; x_range = 0;
      for (int k = 0; k < len; k++) begin qw.push_back(64'h0); ql.push_back(k == len - 1); end
    end else begin
      p = -1;
      for (int i = MX - 1; i >= 0; i--) if (V[i] && p < 0) p = i;
      e = ebig + p - (2 * n + 2);
      sh = p - (n - 1);
      if (sh > 0) begin
        keep = V >> sh; rem = V & ((one << sh) - one); half = one << (sh - 1);
      end else begin
        keep = V << (-sh); rem = '0; half = '0;
      end
      case (md_i)
        0: inc = (sh > 0) && ((rem > half) || (rem == half && keep[0]));
        1: inc = 0;
        2: inc = (rem != '0) && !sgn;
        default: inc = (rem != '0) && sgn;
      endcase
      keep = keep + MX'(inc);
      if (keep[n]) begin keep = one << (n - 1); e = e + 1; end
      x_zero = 0; x_sign = sgn; x_range = (e < 0) || (e > 65535); x_exp = 16'(e);
      for (int k = 0; k < len; k++) begin qw.push_back(keep[k*64 +: 64]); ql.push_back(k == len - 1); end
    end
  endtask

  task automatic run(input string req, input int len, input int ea_i, input int eb_i,
                     input bit sa_i, input bit sb_i, input bit sub_i, input int md_i, input bit poke);
    cur_req = req;
    model(len, ea_i, eb_i, sa_i, sb_i, sub_i, md_i);
    @(negedge clk);
    exp_a = 16'(ea_i); exp_b = 16'(eb_i); sign_a = sa_i; sign_b = sb_i;
    op_sub = sub_i; rmode = 2'(md_i); len_m1 = 2'(len - 1); start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < len; k++) begin
      in_valid = 1; in_word_a = la[k]; in_word_b = lb[k];
      if (poke && k == 0) begin
        // R11: a second start during the load must change nothing
        start = 1; exp_a = exp_a ^ 16'h0100; op_sub = ~op_sub; rmode = ~rmode; len_m1 = 2'd0;
      end
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      start = 0;
    end
    in_valid = 0;
    while (qw.size() != 0 || busy) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished && out_valid) begin
      vectors++;
      if (qw.size() == 0) begin
        miscompares++;
        $display("FAIL %s R9 unexpected word %h, expected no output", cur_req, out_word);
      end else begin
        w_e = qw.pop_front(); l_e = ql.pop_front();
        if (out_word !== w_e || out_last !== l_e || out_exp !== x_exp || out_sign !== x_sign ||
            out_zero !== x_zero || out_range !== x_range) begin
          miscompares++;
          $display("FAIL %s R9 got word=%h last=%b exp=%h sign=%b zero=%b range=%b expected word=%h last=%b exp=%h sign=%b zero=%b range=%b",
                   cur_req, out_word, out_last, out_exp, out_sign, out_zero, out_range,
                   w_e, l_e, x_exp, x_sign, x_zero, x_range);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL %s watchdog expired, got hang, expected completion", cur_req);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; start = 0; op_sub = 0; sign_a = 0; sign_b = 0; in_valid = 0;
    rmode = 0; len_m1 = 0; exp_a = 0; exp_b = 0; in_word_a = 0; in_word_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (busy !== 1'b0 || in_ready !== 1'b0 || out_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset got busy=%b in_ready=%b out_valid=%b expected 0 0 0", busy, in_ready, out_valid);
    end

    // R2: two-word add, bit-level alignment
    la[0] = 64'h1122_3344_5566_7788; la[1] = 64'hC3A5_0F1E_2D3C_4B5A;
    lb[0] = 64'hDEAD_0000_FFFF_0001; lb[1] = 64'hF00D_BEEF_1234_5678;
    run("R2", 2, B, B - 5, 0, 0, 0, 0, 0);
    // R4: carry out of the top bit
    la[0] = H; lb[0] = H;
    run("R4", 1, B, B, 0, 0, 0, 0, 0);
    // R3: b larger, subtraction gives the sign of b
    la[0] = 64'hFFFF_FFFF_FFFF_FFFF; lb[0] = 64'h9000_0000_0000_0001;
    run("R3", 1, B, B + 3, 0, 0, 1, 0, 0);
    run("R3", 1, B, B + 3, 1, 0, 0, 2, 0);
    // R5: deep cancellation
    la[0] = 64'hC000_0000_0000_0001; lb[0] = 64'hC000_0000_0000_0000;
    run("R5", 1, B, B, 0, 0, 1, 0, 0);
    la[0] = 64'h0000_0000_0000_0007; la[1] = 64'hA000_0000_0000_0000;
    lb[0] = 64'hFFFF_FFFF_FFFF_FFF0; lb[1] = 64'h9FFF_FFFF_FFFF_FFFF;
    run("R5", 2, B, B, 0, 0, 1, 1, 0);
    // R8: exact cancellation in three ways
    la[0] = 64'h0123_4567_89AB_CDEF; la[1] = 64'hB000_0000_0000_1234;
    lb[0] = la[0]; lb[1] = la[1];
    run("R8", 2, B, B, 0, 0, 1, 0, 0);
    run("R8", 2, B, B, 0, 0, 1, 3, 0);
    run("R8", 2, B, B, 0, 1, 0, 2, 0);
    // R6: every mode, both signs, inexact with sticky
    la[0] = 64'h0000_0000_0000_0010; la[1] = 64'h8000_0000_0000_0000;
    lb[0] = 64'h1234_5678_9ABC_DEF1; lb[1] = 64'hE000_0000_0000_0003;
    for (int m = 0; m < 4; m++) begin
      run("R6", 2, B, B - 70, 0, 0, 0, m, 0);
      run("R6", 2, B, B - 70, 1, 1, 0, m, 0);
      run("R6", 2, B, B - 2, 1, 0, 0, m, 0);
    end
    // R6: exact tie for nearest-even
    la[0] = 64'h8000_0000_0000_0001; lb[0] = H;
    run("R6", 1, B, B - 64, 0, 0, 0, 0, 0);
    la[0] = 64'h8000_0000_0000_0002;
    run("R6", 1, B, B - 64, 0, 0, 0, 0, 0);
    // R7: round-up overflow
    la[0] = 64'hFFFF_FFFF_FFFF_FFFF; lb[0] = 64'hC000_0000_0000_0000;
    run("R7", 1, B, B - 64, 0, 0, 0, 0, 0);
    // R12: far operand only through sticky
    la[0] = 64'h0; la[1] = 64'h0; la[2] = H;
    lb[0] = 64'h5; lb[1] = 64'h0; lb[2] = 64'hFFFF_0000_0000_0000;
    run("R12", 3, B, B - 1000, 0, 0, 1, 3, 0);
    run("R12", 3, B, B - 1000, 0, 0, 1, 2, 0);
    run("R12", 3, B, B - 1000, 0, 0, 0, 2, 0);
    // R10: exponent overflow and underflow
    la[0] = H; lb[0] = H;
    run("R10", 1, 65535, 65535, 0, 0, 0, 0, 0);
    la[0] = 64'hC000_0000_0000_0000; lb[0] = 64'hB000_0000_0000_0000;
    run("R10", 1, 1, 1, 0, 0, 1, 0, 0);
    // R11: start during load is ignored
    la[0] = 64'h0F0F_0F0F_0F0F_0F0F; la[1] = 64'h9999_AAAA_BBBB_CCCC;
    lb[0] = 64'h1357_9BDF_2468_ACE0; lb[1] = 64'hD000_0000_0000_0000;
    run("R11", 2, B + 1, B, 0, 0, 0, 0, 1);
    // R2 R3 R6: mixed patterns over all lengths
    for (int t = 0; t < 48; t++) begin
      int len, ea_i, eb_i;
      logic [63:0] rv;
      rv = nxt();
      len = int'(rv[1:0]) + 1;
      for (int k = 0; k < 4; k++) begin la[k] = nxt(); lb[k] = nxt(); end
      la[len-1][63] = 1'b1; lb[len-1][63] = 1'b1;
      ea_i = B + int'(rv[7:4]);
      eb_i = ea_i + int'(rv[17:8] % 10'd300) - 150;
      if (rv[20]) eb_i = ea_i;
      run("R2 R3 R6", len, ea_i, eb_i, rv[21], rv[22], rv[23], int'(rv[25:24]), 0);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule